// File: doc/BRIEF.md
# DRAM Row Command Sequencer

This block sits between a single requester and a DRAM command bus. Each request names a bank, a row and a column, says whether it is a read or a write, and carries a tag. The sequencer keeps its own record of which row is open in each bank. From that record it works out the shortest legal command path for the request:

- If the bank is closed, it activates the row and then issues the column command.
- If the request hits the open row, it issues the column command straight away.
- If the request misses the open row, it closes that row, activates the new one, and then issues the column command.

Every bank has its own timers. These timers enforce the spacing from precharge to activate, from activate to column command, and from activate to precharge. A row switch in one bank therefore never disturbs the state of another bank.

At most one command is driven per cycle, and every command is issued at the earliest cycle its timers allow. A request stays pending until its column command has been chosen. Reads are echoed back as a tagged valid pulse CAS-latency cycles after the read command.

Top module: `dram_cmd_seq`

## Requirements
- R1: After reset, all banks are closed, `cmd_o` is NOP, `req_ready_o` is low and `rd_valid_o` is low.
- R2: `cmd_o` uses the code NOP=0, ACT=1, PRE=2, RD=3, WR=4 and carries one command per cycle. `cmd_bank_o` holds the target bank. `cmd_addr_o` holds the row for ACT or the column for RD/WR, zero-extended, and is 0 for NOP and PRE.
- R3: A request to a closed bank issues ACT with no PRE before it. Its column command is chosen after exactly T_RCD waiting cycles.
- R4: A request to the open row of a bank issues only its column command, with no waiting cycle.
- R5: A request to a different row of an open bank issues PRE, then ACT, then the column command. Once the row has been open for at least T_RAS cycles, this takes T_RP+T_RCD waiting cycles.
- R6: ACT to a bank appears on `cmd_o` no earlier than T_RP cycles after the last PRE to that bank.
- R7: RD or WR to a bank appears no earlier than T_RCD cycles after the ACT to that bank.
- R8: PRE to a bank appears no earlier than T_RAS cycles after the ACT to that bank. A miss issued right after an activation therefore waits T_RAS+T_RP-1 cycles.
- R9: Each command appears on `cmd_o` in the cycle after it is chosen, at the earliest cycle all its spacing rules permit. Every other cycle drives NOP.
- R10: `req_ready_o` is high only in the cycle in which the column command for the presented request is chosen. That RD or WR appears on `cmd_o` in the next cycle.
- R11: `rd_valid_o` pulses exactly T_CL cycles after each RD on `cmd_o`, and `rd_tag_o` carries that request's tag. WR never produces a pulse.
- R12: Activity in one bank leaves the open row and timers of the other banks unchanged. A closed or open-row request to another bank is served with its own latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request accepted; its column command is chosen this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_bank_i | input | BANK_W | Target bank |
| req_row_i | input | ROW_W | Target row |
| req_col_i | input | COL_W | Target column |
| req_tag_i | input | TAG_W | Tag returned with read data valid |
| cmd_o | output | 3 | Command code |
| cmd_bank_o | output | BANK_W | Bank of the command |
| cmd_addr_o | output | ADDR_W | Row for ACT, column for RD/WR |
| rd_valid_o | output | 1 | Read data due |
| rd_tag_o | output | TAG_W | Tag of the read whose data is due |

## Verification
The bench builds the block with 4 banks, 4-bit row and column fields, T_RP=3, T_RCD=3, T_CL=4 and T_RAS=6.

With T_RAS twice T_RCD, a miss that follows an activation visibly stalls on the row-active minimum. With a CAS latency longer than the gap between back-to-back hits, several read pulses are in flight at once.

Random rows are drawn from only three values per bank. This makes hits, misses and closed-bank starts all frequent. Every cycle is compared against a timestamp-based model of the spacing rules.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_PRE = 3'd2,
    CMD_RD  = 3'd3,
    CMD_WR  = 3'd4
  } dram_cmd_e;

  typedef struct packed {
    logic is_open;
    logic act_ok;
    logic col_ok;
    logic pre_ok;
  } bank_flags_t;

endpackage

// File: rtl/dram_bank_track.sv
module dram_bank_track
  import dram_seq_pkg::*;
#(
  parameter int ROW_W = 14,
  parameter int T_RP  = 14,
  parameter int T_RCD = 14,
  parameter int T_RAS = 34
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             act_i,
  input  logic             pre_i,
  input  logic [ROW_W-1:0] row_i,
  output bank_flags_t      flags_o,
  output logic [ROW_W-1:0] row_o
);

  localparam int TMAX = (T_RAS > T_RP) ? ((T_RAS > T_RCD) ? T_RAS : T_RCD)
                                       : ((T_RP > T_RCD) ? T_RP : T_RCD);
  localparam int CW = $clog2(TMAX + 1);

  logic             open_q;
  logic [ROW_W-1:0] row_q;
  logic [CW-1:0]    rp_q, rcd_q, ras_q;

  // a load value of T-1 lets the dependent command appear exactly T cycles later
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= 1'b0;
      row_q  <= '0;
      rp_q   <= '0;
      rcd_q  <= '0;
      ras_q  <= '0;
    end else begin
      if (rp_q  != '0) rp_q  <= rp_q  - 1'b1;
      if (rcd_q != '0) rcd_q <= rcd_q - 1'b1;
      if (ras_q != '0) ras_q <= ras_q - 1'b1;
      if (act_i) begin
        open_q <= 1'b1;
        row_q  <= row_i;
        rcd_q  <= CW'(T_RCD - 1);
        ras_q  <= CW'(T_RAS - 1);
      end
      if (pre_i) begin
        open_q <= 1'b0;
        rp_q   <= CW'(T_RP - 1);
      end
    end
  end

  assign flags_o.is_open = open_q;
  assign flags_o.act_ok  = (rp_q == '0);
  assign flags_o.col_ok  = (rcd_q == '0);
  assign flags_o.pre_ok  = (ras_q == '0);
  assign row_o           = row_q;

endmodule

// File: rtl/dram_cmd_pick.sv
module dram_cmd_pick
  import dram_seq_pkg::*;
#(
  parameter int ROW_W = 14
) (
  input  logic             valid_i,
  input  logic             write_i,
  input  logic [ROW_W-1:0] row_i,
  input  bank_flags_t      flags_i,
  input  logic [ROW_W-1:0] open_row_i,
  output dram_cmd_e        cmd_o,
  output logic             col_go_o
);

  always_comb begin
    cmd_o    = CMD_NOP;
    col_go_o = 1'b0;
    if (valid_i) begin
      if (!flags_i.is_open) begin
        if (flags_i.act_ok) cmd_o = CMD_ACT;
      end else if (row_i == open_row_i) begin
        if (flags_i.col_ok) begin
          cmd_o    = write_i ? CMD_WR : CMD_RD;
          col_go_o = 1'b1;
        end
      end else if (flags_i.pre_ok) begin
        cmd_o = CMD_PRE;
      end
    end
  end

endmodule

// File: rtl/dram_rd_pipe.sv
module dram_rd_pipe #(
  parameter int TAG_W = 4,
  parameter int DEPTH = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [TAG_W-1:0] tag_i,
  output logic             valid_o,
  output logic [TAG_W-1:0] tag_o
);

  logic             v_q [DEPTH];
  logic [TAG_W-1:0] t_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) begin
        v_q[i] <= 1'b0;
        t_q[i] <= '0;
      end
    end else begin
      v_q[0] <= valid_i;
      t_q[0] <= tag_i;
      for (int i = 1; i < DEPTH; i++) begin
        v_q[i] <= v_q[i-1];
        t_q[i] <= t_q[i-1];
      end
    end
  end

  assign valid_o = v_q[DEPTH-1];
  assign tag_o   = t_q[DEPTH-1];

endmodule

// File: rtl/dram_cmd_seq.sv
module dram_cmd_seq
  import dram_seq_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 14,
  parameter int COL_W     = 10,
  parameter int TAG_W     = 4,
  parameter int T_RP      = 14,
  parameter int T_RCD     = 14,
  parameter int T_CL      = 14,
  parameter int T_RAS     = 34,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int ADDR_W   = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [BANK_W-1:0] req_bank_i,
  input  logic [ROW_W-1:0]  req_row_i,
  input  logic [COL_W-1:0]  req_col_i,
  input  logic [TAG_W-1:0]  req_tag_i,
  output logic [2:0]        cmd_o,
  output logic [BANK_W-1:0] cmd_bank_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic              rd_valid_o,
  output logic [TAG_W-1:0]  rd_tag_o
);

  bank_flags_t      flags    [NUM_BANKS];
  logic [ROW_W-1:0] open_row [NUM_BANKS];
  dram_cmd_e        pick_cmd;
  logic             col_go;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit_bank;
    assign hit_bank = (req_bank_i == BANK_W'(b));

    dram_bank_track #(
      .ROW_W(ROW_W), .T_RP(T_RP), .T_RCD(T_RCD), .T_RAS(T_RAS)
    ) i_track (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .act_i   (hit_bank && (pick_cmd == CMD_ACT)),
      .pre_i   (hit_bank && (pick_cmd == CMD_PRE)),
      .row_i   (req_row_i),
      .flags_o (flags[b]),
      .row_o   (open_row[b])
    );
  end

  dram_cmd_pick #(.ROW_W(ROW_W)) i_pick (
    .valid_i    (req_valid_i),
    .write_i    (req_write_i),
    .row_i      (req_row_i),
    .flags_i    (flags[req_bank_i]),
    .open_row_i (open_row[req_bank_i]),
    .cmd_o      (pick_cmd),
    .col_go_o   (col_go)
  );

  assign req_ready_o = col_go;

  dram_cmd_e         cmd_q;
  logic [BANK_W-1:0] bank_q;
  logic [ADDR_W-1:0] addr_q;
  logic [TAG_W-1:0]  tag_q;
  logic [ADDR_W-1:0] addr_d;

  always_comb begin
    unique case (pick_cmd)
      CMD_ACT:        addr_d = ADDR_W'(req_row_i);
      CMD_RD, CMD_WR: addr_d = ADDR_W'(req_col_i);
      default:        addr_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= CMD_NOP;
      bank_q <= '0;
      addr_q <= '0;
      tag_q  <= '0;
    end else begin
      cmd_q  <= pick_cmd;
      bank_q <= (pick_cmd == CMD_NOP) ? '0 : req_bank_i;
      addr_q <= addr_d;
      tag_q  <= req_tag_i;
    end
  end

  assign cmd_o      = cmd_q;
  assign cmd_bank_o = bank_q;
  assign cmd_addr_o = addr_q;

  dram_rd_pipe #(.TAG_W(TAG_W), .DEPTH(T_CL)) i_rd_pipe (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (cmd_q == CMD_RD),
    .tag_i   (tag_q),
    .valid_o (rd_valid_o),
    .tag_o   (rd_tag_o)
  );

endmodule

// File: rtl/dram_cmd_seq_chk.sv
module dram_cmd_seq_chk
  import dram_seq_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int T_RP      = 14,
  parameter int T_RCD     = 14,
  parameter int T_RAS     = 34,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic [2:0]        cmd_o,
  input logic [BANK_W-1:0] cmd_bank_o
);

  localparam int SAT = T_RAS + T_RP + T_RCD;
  localparam int CW  = $clog2(SAT + 1);

  logic [CW-1:0] since_act [NUM_BANKS];
  logic [CW-1:0] since_pre [NUM_BANKS];
  logic          sh_open   [NUM_BANKS];
  logic          is_col;

  assign is_col = (cmd_o == CMD_RD) || (cmd_o == CMD_WR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        since_act[b] <= CW'(SAT);
        since_pre[b] <= CW'(SAT);
        sh_open[b]   <= 1'b0;
      end
    end else begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (since_act[b] != CW'(SAT)) since_act[b] <= since_act[b] + 1'b1;
        if (since_pre[b] != CW'(SAT)) since_pre[b] <= since_pre[b] + 1'b1;
        if (cmd_bank_o == BANK_W'(b)) begin
          if (cmd_o == CMD_ACT) begin
            since_act[b] <= CW'(1);
            sh_open[b]   <= 1'b1;
          end
          if (cmd_o == CMD_PRE) begin
            since_pre[b] <= CW'(1);
            sh_open[b]   <= 1'b0;
          end
        end
      end
    end
  end

  p_code_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_o <= 3'd4);

  p_act_closed_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_ACT) |-> !sh_open[cmd_bank_o]);

  p_col_open_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_col |-> sh_open[cmd_bank_o]);

  p_rp_gap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_ACT) |-> (since_pre[cmd_bank_o] >= CW'(T_RP)));

  p_rcd_gap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_col |-> (since_act[cmd_bank_o] >= CW'(T_RCD)));

  p_ras_gap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_PRE) |-> (since_act[cmd_bank_o] >= CW'(T_RAS)));

  p_ready_col_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |=> is_col);

  p_ready_valid_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> req_valid_i);

endmodule

bind dram_cmd_seq dram_cmd_seq_chk #(
  .NUM_BANKS(NUM_BANKS), .T_RP(T_RP), .T_RCD(T_RCD), .T_RAS(T_RAS)
) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .cmd_o       (cmd_o),
  .cmd_bank_o  (cmd_bank_o)
);

// File: tb/test_dram_cmd_seq.sv
module test_dram_cmd_seq;
  localparam int NB = 4, RW = 4, CLW = 4, TW = 4;
  localparam int TRP = 3, TRCD = 3, TCL = 4, TRAS = 6;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk = ~clk;

  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]    req_bank = '0;
  logic [RW-1:0] req_row = '0;
  logic [CLW-1:0] req_col = '0;
  logic [TW-1:0] req_tag = '0;
  logic          req_ready;
  logic [2:0]    cmd;
  logic [1:0]    cmd_bank;
  logic [3:0]    cmd_addr;
  logic          rd_valid;
  logic [TW-1:0] rd_tag;

  dram_cmd_seq #(
    .NUM_BANKS(NB), .ROW_W(RW), .COL_W(CLW), .TAG_W(TW),
    .T_RP(TRP), .T_RCD(TRCD), .T_CL(TCL), .T_RAS(TRAS)
  ) i_dram_cmd_seq (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_bank_i(req_bank), .req_row_i(req_row), .req_col_i(req_col),
    .req_tag_i(req_tag), .cmd_o(cmd), .cmd_bank_o(cmd_bank),
    .cmd_addr_o(cmd_addr), .rd_valid_o(rd_valid), .rd_tag_o(rd_tag)
  );

  int total = 0, bad = 0, cyc = 0;
  int n_rd = 0, n_rdv = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  always @(posedge clk) cyc++;

  // reference model: timestamps of the last ACT/PRE per bank
  bit m_open [NB];
  int m_row [NB], t_act [NB], t_pre [NB];
  int p_cmd = 0, p_bank = 0, p_addr = 0, p_tag = 0;
  bit rdv_exp [64];
  int rdt_exp [64];

  initial begin
    for (int b = 0; b < NB; b++) begin
      m_open[b] = 0; m_row[b] = 0; t_act[b] = -100; t_pre[b] = -100;
    end
    for (int i = 0; i < 64; i++) begin rdv_exp[i] = 0; rdt_exp[i] = 0; end
  end

  always @(negedge clk) begin
    if (rst_ni) begin
      string kind;
      int e, b;
      bit col;
      case (p_cmd)
        1: kind = "R6";
        2: kind = "R8";
        3, 4: kind = "R7";
        default: kind = "R9";
      endcase
      chk(int'(cmd) == p_cmd, kind, cmd, p_cmd);
      chk(int'(cmd_addr) == p_addr, "R2", cmd_addr, p_addr);
      if (p_cmd != 0) chk(int'(cmd_bank) == p_bank, "R2", cmd_bank, p_bank);
      case (p_cmd)
        1: begin m_open[p_bank] = 1; m_row[p_bank] = p_addr; t_act[p_bank] = cyc; end
        2: begin m_open[p_bank] = 0; t_pre[p_bank] = cyc; end
        3: begin
          rdv_exp[(cyc + TCL) % 64] = 1;
          rdt_exp[(cyc + TCL) % 64] = p_tag;
          n_rd++;
        end
        default: ;
      endcase
      chk(rd_valid == rdv_exp[cyc % 64], "R11", rd_valid, rdv_exp[cyc % 64]);
      if (rd_valid) n_rdv++;
      if (rd_valid && rdv_exp[cyc % 64])
        chk(int'(rd_tag) == rdt_exp[cyc % 64], "R11", rd_tag, rdt_exp[cyc % 64]);
      rdv_exp[cyc % 64] = 0;

      e = 0; col = 0; b = int'(req_bank);
      if (req_valid) begin
        if (!m_open[b]) begin
          if (cyc + 1 - t_pre[b] >= TRP) e = 1;
        end else if (int'(req_row) == m_row[b]) begin
          if (cyc + 1 - t_act[b] >= TRCD) begin e = req_write ? 4 : 3; col = 1; end
        end else if (cyc + 1 - t_act[b] >= TRAS) begin
          e = 2;
        end
      end
      chk(req_ready == col, "R10", req_ready, col);
      p_cmd = e; p_bank = b; p_tag = int'(req_tag);
      p_addr = (e == 1) ? int'(req_row) : ((e >= 3) ? int'(req_col) : 0);
    end
  end

  task automatic do_req(input bit w, input int b, input int r, input int c,
                        input int t, output int waits);
    req_write = w; req_bank = 2'(b); req_row = RW'(r); req_col = CLW'(c);
    req_tag = TW'(t); req_valid = 1'b1;
    waits = 0;
    forever begin
      @(negedge clk);
      if (req_ready || waits > 200) break;
      waits++;
    end
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000 - 50000) @(posedge clk);
    total++; bad++;
    $display("FAIL R9 watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    int w;
    void'($urandom(32'd4711));
    repeat (2) @(negedge clk);
    // R1: reset state
    chk(cmd == 3'd0, "R1", cmd, 0);
    chk(req_ready == 1'b0, "R1", req_ready, 0);
    chk(rd_valid == 1'b0, "R1", rd_valid, 0);
    @(posedge clk); #1 rst_ni = 1'b1;
    idle(2);

    do_req(0, 0, 1, 2, 1, w);  chk(w == TRCD, "R3", w, TRCD);
    do_req(0, 0, 2, 5, 2, w);  chk(w == TRAS + TRP - 1, "R8", w, TRAS + TRP - 1);
    do_req(0, 0, 2, 6, 3, w);  chk(w == 0, "R4", w, 0);
    do_req(1, 0, 2, 7, 4, w);  chk(w == 0, "R4", w, 0);
    do_req(0, 0, 2, 8, 5, w);  chk(w == 0, "R4", w, 0);
    idle(10);
    do_req(0, 0, 3, 1, 6, w);  chk(w == TRP + TRCD, "R5", w, TRP + TRCD);
    do_req(1, 1, 5, 2, 7, w);  chk(w == TRCD, "R12", w, TRCD);
    do_req(0, 2, 9, 3, 8, w);  chk(w == TRCD, "R12", w, TRCD);
    do_req(0, 0, 3, 4, 9, w);  chk(w == 0, "R12", w, 0);
    do_req(1, 1, 5, 5, 10, w); chk(w == 0, "R12", w, 0);
    idle(8);

    for (int i = 0; i < 300; i++) begin
      do_req(1'($urandom % 2), int'($urandom % NB), int'($urandom % 3),
             int'($urandom % 16), int'($urandom % 16), w);
      chk(w <= TRAS + TRP + TRCD, "R9", w, TRAS + TRP + TRCD);
      if ($urandom % 4 == 0) idle(int'($urandom % 4));
    end
    idle(TCL + 4);
    chk(n_rdv == n_rd, "R11", n_rdv, n_rd);
    finish_run();
  end

endmodule